// File: doc/BRIEF.md
# Transmit Buffer Request and Cancellation Tracker

This block holds the control state for a small set of transmit buffers in a CAN-style controller. The host marks buffers for sending by writing an add-request mask, and withdraws them by writing a cancel-request mask. Each buffer carries a message identifier. A sequential scan walks the pending buffers, one per cycle, and offers the one with the numerically lowest identifier to the protocol engine. The engine then reports how that frame ended: success, lost arbitration, or error.

Cancellation of a buffer that is on the bus waits until its frame ends. The block keeps separate per-buffer status sets for "frame sent" and "cancellation finished", each with its own enable mask, and each set drives one combined interrupt. With automatic retransmission disabled, a frame that does not succeed is withdrawn and reported as cancelled. The bit-level transmitter and the buffer payload storage live elsewhere.

Top module: `txq_tracker`

## Requirements
- R1: While no scan is running, a cycle with `add_we` high sets every `pend` bit whose `add_mask` bit is 1, visible after the next clock edge. Zero mask bits change nothing, and `add_hold` stays zero.
- R2: An add request written while `scan_busy` is high is parked in `add_hold`, and `pend` does not change. The parked bits move into `pend` when the scan ends, and `add_hold` is then zero.
- R3: When `sel_valid` is high, `sel_idx` names the pending buffer with the lowest identifier. Buffer i's identifier is `buf_ids[i*IDW +: IDW]`, and on equal identifiers the lower index wins.
- R4: `eng_ok` for the buffer on the bus clears its `pend` bit and sets its `tx_done` bit at the next edge.
- R5: A cancel write sets `cxl_req` for a buffer that is pending. The bit stays set until that buffer's `pend` bit clears, and both clear at the same edge.
- R6: A cancel of a pending buffer that is not on the bus clears `pend` and sets `cxl_done` one edge after `cxl_req` appears. A cancel of a buffer that is not pending sets `cxl_done` at the next edge.
- R7: A cancel of the buffer on the bus leaves it pending until the frame ends. If the frame then succeeds, `tx_done` and `cxl_done` are both set at the same edge.
- R8: With a cancel outstanding, `eng_lost` or `eng_err` completes the cancellation: `pend` clears, `cxl_done` sets, and `tx_done` stays clear. With no cancel and retransmission on, the buffer stays pending and is offered again.
- R9: With `no_retry` high, `eng_lost` or `eng_err` clears the buffer's `pend` bit and sets its `cxl_done` bit.
- R10: An add write for a buffer clears that buffer's `tx_done` and `cxl_done` bits at the next edge.
- R11: `irq_tc` is high exactly when some buffer has both `tx_done` and its `tie_en` bit set. `irq_cf` is the same for `cxl_done` and `cfie_en`.
- R12: `sel_valid` is low while a frame is on the bus (`tx_busy`) or a scan is running. An accepted `eng_start` makes `tx_busy` high, with `busy_idx` equal to the offered index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| add_we | input | 1 | Add-request write strobe |
| add_mask | input | NBUF | Buffers to request |
| cxl_we | input | 1 | Cancel-request write strobe |
| cxl_mask | input | NBUF | Buffers to cancel |
| buf_ids | input | NBUF*IDW | Message identifier of each buffer |
| no_retry | input | 1 | Disable automatic retransmission |
| tie_en | input | NBUF | Sent-status interrupt enables |
| cfie_en | input | NBUF | Cancel-finished interrupt enables |
| eng_start | input | 1 | Engine takes the offered buffer |
| eng_ok | input | 1 | Frame on bus completed successfully |
| eng_lost | input | 1 | Frame on bus lost arbitration |
| eng_err | input | 1 | Frame on bus ended in error |
| sel_valid | output | 1 | A buffer is offered to the engine |
| sel_idx | output | IDXW | Offered buffer index |
| tx_busy | output | 1 | A frame is on the bus |
| busy_idx | output | IDXW | Index of buffer on the bus |
| scan_busy | output | 1 | Priority scan in progress |
| pend | output | NBUF | Pending bits |
| cxl_req | output | NBUF | Cancel-request bits |
| add_hold | output | NBUF | Add requests parked during a scan |
| tx_done | output | NBUF | Transmission-occurred bits |
| cxl_done | output | NBUF | Cancellation-finished bits |
| irq_tc | output | 1 | Combined sent interrupt |
| irq_cf | output | 1 | Combined cancel-finished interrupt |

## Verification
The bench builds the block with three buffers and 4-bit identifiers. It sweeps every non-empty pending mask against every identifier assignment drawn from the values 0 to 3. That small range forces ties often, so the lowest-identifier choice and the index tie-break are checked over all 448 combinations. Each combination ends with a cancel of all buffers, which exercises the pending and non-pending cancel paths. Directed sequences then cover add requests parked during a scan, deferred cancellation, retry after error, and the no-retry mode.

// File: rtl/txq_pkg.sv
package txq_pkg;

    // Per-buffer control and status bits
    typedef struct packed {
        logic pend;   // awaiting transmission
        logic creq;   // cancel requested
        logic hold;   // add request parked during scan
        logic tdone;  // transmission occurred
        logic cdone;  // cancellation finished
    } slot_t;

    // Outcome reported by the protocol engine
    typedef enum logic [1:0] {
        FIN_NONE = 2'd0,
        FIN_OK   = 2'd1,
        FIN_FAIL = 2'd2
    } fin_e;

endpackage

// File: rtl/txq_slot.sv
module txq_slot
    import txq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  add_wr,
    input  logic  cxl_wr,
    input  logic  scan_busy,
    input  logic  merge,
    input  logic  on_bus,
    input  fin_e  fin,
    input  logic  no_retry,
    output slot_t st,
    output logic  pend_chg
);

    slot_t q, d;
    logic  pend_clr, pend_set, cdone_set, cancel_idle;

    always_comb begin
        d = q;
        // cancel of a buffer that is pending but not on the bus
        cancel_idle = !on_bus && q.creq && q.pend;
        pend_clr    = (fin == FIN_OK)
                   || ((fin == FIN_FAIL) && (q.creq || no_retry))
                   || cancel_idle;
        pend_set    = (add_wr && !scan_busy) || (q.hold && merge);
        cdone_set   = ((fin == FIN_OK) && q.creq)
                   || ((fin == FIN_FAIL) && (q.creq || no_retry))
                   || cancel_idle
                   || (cxl_wr && !q.pend && !on_bus);

        d.hold  = (q.hold && !merge) || (add_wr && scan_busy);
        d.pend  = (q.pend && !pend_clr) || pend_set;
        d.creq  = (q.creq || (cxl_wr && (q.pend || on_bus))) && !pend_clr;
        d.tdone = (q.tdone && !add_wr) || (fin == FIN_OK);
        d.cdone = (q.cdone && !add_wr) || cdone_set;
        pend_chg = d.pend != q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign st = q;

endmodule

// File: rtl/txq_scan.sv
module txq_scan #(
    parameter int NBUF = 3,
    parameter int IDW  = 11,
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NBUF-1:0]   pend,
    input  logic [NBUF*IDW-1:0] ids,
    output logic              busy,
    output logic              done,
    output logic              res_v,
    output logic [IDXW-1:0]   res_idx
);

    localparam logic [IDXW-1:0] LAST = IDXW'(NBUF - 1);

    typedef struct packed {
        logic            busy;
        logic [IDXW-1:0] cnt;
        logic            best_v;
        logic [IDXW-1:0] best_idx;
        logic [IDW-1:0]  best_id;
        logic            res_v;
        logic [IDXW-1:0] res_idx;
    } scan_t;

    scan_t q, d;
    logic [IDW-1:0] cur_id;
    logic           take;

    always_comb begin
        d      = q;
        cur_id = ids[int'(q.cnt)*IDW +: IDW];
        // strict compare: equal identifiers keep the earlier (lower) index
        take   = pend[q.cnt] && (!q.best_v || (cur_id < q.best_id));
        if (start) begin
            d.busy   = 1'b1;
            d.cnt    = '0;
            d.best_v = 1'b0;
        end else if (q.busy) begin
            if (take) begin
                d.best_v   = 1'b1;
                d.best_idx = q.cnt;
                d.best_id  = cur_id;
            end
            if (q.cnt == LAST) begin
                d.busy    = 1'b0;
                d.res_v   = take || q.best_v;
                d.res_idx = take ? q.cnt : q.best_idx;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign done    = q.busy && (q.cnt == LAST);
    assign res_v   = q.res_v;
    assign res_idx = q.res_idx;

endmodule

// File: rtl/txq_irq.sv
module txq_irq #(
    parameter int NBUF = 3
) (
    input  logic [NBUF-1:0] tdone,
    input  logic [NBUF-1:0] tie,
    input  logic [NBUF-1:0] cdone,
    input  logic [NBUF-1:0] cfie,
    output logic            irq_tc,
    output logic            irq_cf
);

    always_comb begin
        irq_tc = |(tdone & tie);
        irq_cf = |(cdone & cfie);
    end

endmodule

// File: rtl/txq_tracker.sv
module txq_tracker
    import txq_pkg::*;
#(
    parameter int NBUF = 3,
    parameter int IDW  = 11,
    localparam int IDXW = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                add_we,
    input  logic [NBUF-1:0]     add_mask,
    input  logic                cxl_we,
    input  logic [NBUF-1:0]     cxl_mask,
    input  logic [NBUF*IDW-1:0] buf_ids,
    input  logic                no_retry,
    input  logic [NBUF-1:0]     tie_en,
    input  logic [NBUF-1:0]     cfie_en,
    input  logic                eng_start,
    input  logic                eng_ok,
    input  logic                eng_lost,
    input  logic                eng_err,
    output logic                sel_valid,
    output logic [IDXW-1:0]     sel_idx,
    output logic                tx_busy,
    output logic [IDXW-1:0]     busy_idx,
    output logic                scan_busy,
    output logic [NBUF-1:0]     pend,
    output logic [NBUF-1:0]     cxl_req,
    output logic [NBUF-1:0]     add_hold,
    output logic [NBUF-1:0]     tx_done,
    output logic [NBUF-1:0]     cxl_done,
    output logic                irq_tc,
    output logic                irq_cf
);

    typedef struct packed {
        logic            fly_v;
        logic [IDXW-1:0] fly_idx;
        logic            need;
    } top_t;

    top_t q, d;

    slot_t [NBUF-1:0] st;
    logic  [NBUF-1:0] pend_chg;
    logic  [NBUF-1:0] on_bus;
    fin_e  [NBUF-1:0] fin;
    logic             scan_done, scan_start, res_v, merge, start_acc, fin_any;
    logic [IDXW-1:0]  res_idx;

    always_comb begin
        merge      = scan_done || !scan_busy;
        scan_start = q.need && !scan_busy;
        sel_valid  = res_v && !scan_busy && !q.need && !q.fly_v
                  && pend[res_idx] && !cxl_req[res_idx];
        start_acc  = eng_start && sel_valid;
        fin_any    = q.fly_v && (eng_ok || eng_lost || eng_err);
        for (int i = 0; i < NBUF; i++) begin
            on_bus[i] = (q.fly_v && (q.fly_idx == IDXW'(i)))
                     || (start_acc && (res_idx == IDXW'(i)));
            if (q.fly_v && (q.fly_idx == IDXW'(i)) && eng_ok)
                fin[i] = FIN_OK;
            else if (q.fly_v && (q.fly_idx == IDXW'(i)) && (eng_lost || eng_err))
                fin[i] = FIN_FAIL;
            else
                fin[i] = FIN_NONE;
        end

        d = q;
        if (start_acc) begin
            d.fly_v   = 1'b1;
            d.fly_idx = res_idx;
        end else if (fin_any) begin
            d.fly_v = 1'b0;
        end
        d.need = (q.need && !scan_start) || (|pend_chg);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_slot
        txq_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .add_wr   (add_we && add_mask[g]),
            .cxl_wr   (cxl_we && cxl_mask[g]),
            .scan_busy(scan_busy),
            .merge    (merge),
            .on_bus   (on_bus[g]),
            .fin      (fin[g]),
            .no_retry (no_retry),
            .st       (st[g]),
            .pend_chg (pend_chg[g])
        );
        assign pend[g]     = st[g].pend;
        assign cxl_req[g]  = st[g].creq;
        assign add_hold[g] = st[g].hold;
        assign tx_done[g]  = st[g].tdone;
        assign cxl_done[g] = st[g].cdone;
    end

    txq_scan #(.NBUF(NBUF), .IDW(IDW)) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (scan_start),
        .pend   (pend),
        .ids    (buf_ids),
        .busy   (scan_busy),
        .done   (scan_done),
        .res_v  (res_v),
        .res_idx(res_idx)
    );

    txq_irq #(.NBUF(NBUF)) u_irq (
        .tdone (tx_done),
        .tie   (tie_en),
        .cdone (cxl_done),
        .cfie  (cfie_en),
        .irq_tc(irq_tc),
        .irq_cf(irq_cf)
    );

    assign sel_idx  = res_idx;
    assign tx_busy  = q.fly_v;
    assign busy_idx = q.fly_idx;

endmodule

// File: rtl/txq_chk.sv
module txq_chk #(
    parameter int NBUF = 3,
    parameter int IDXW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            eng_ok,
    input logic            eng_lost,
    input logic            eng_err,
    input logic            no_retry,
    input logic [NBUF-1:0] tie_en,
    input logic            sel_valid,
    input logic [IDXW-1:0] sel_idx,
    input logic            tx_busy,
    input logic [IDXW-1:0] busy_idx,
    input logic            scan_busy,
    input logic [NBUF-1:0] pend,
    input logic [NBUF-1:0] cxl_req,
    input logic [NBUF-1:0] add_hold,
    input logic [NBUF-1:0] tx_done,
    input logic [NBUF-1:0] cxl_done,
    input logic            irq_tc
);

    // R12
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (!tx_busy && !scan_busy));

    // R3
    sel_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> pend[sel_idx]);

    // R5
    creq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cxl_req & ~pend) == '0);

    // R2
    hold_only_near_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (add_hold != '0) |-> (scan_busy || $past(scan_busy)));

    // R7
    bus_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !eng_ok && !eng_lost && !eng_err) |=> pend[$past(busy_idx)]);

    // R4
    ok_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && eng_ok) |=> (tx_done[$past(busy_idx)] && !pend[$past(busy_idx)]));

    // R9
    noretry_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && !eng_ok && (eng_lost || eng_err) && no_retry)
        |=> (cxl_done[$past(busy_idx)] && !pend[$past(busy_idx)]));

    // R11
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tc |-> ((tx_done & tie_en) != '0));

endmodule

bind txq_tracker txq_chk #(.NBUF(NBUF), .IDXW(IDXW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_ok   (eng_ok),
    .eng_lost (eng_lost),
    .eng_err  (eng_err),
    .no_retry (no_retry),
    .tie_en   (tie_en),
    .sel_valid(sel_valid),
    .sel_idx  (sel_idx),
    .tx_busy  (tx_busy),
    .busy_idx (busy_idx),
    .scan_busy(scan_busy),
    .pend     (pend),
    .cxl_req  (cxl_req),
    .add_hold (add_hold),
    .tx_done  (tx_done),
    .cxl_done (cxl_done),
    .irq_tc   (irq_tc)
);

// File: tb/sim_txq_tracker.sv
`timescale 1ns/1ps
module sim_txq_tracker;

    localparam int NBUF = 3;
    localparam int IDW  = 4;
    localparam int IDXW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic add_we = 0, cxl_we = 0, no_retry = 0;
    logic [NBUF-1:0] add_mask = '0, cxl_mask = '0, tie_en = '0, cfie_en = '0;
    logic [NBUF*IDW-1:0] buf_ids = '0;
    logic eng_start = 0, eng_ok = 0, eng_lost = 0, eng_err = 0;
    logic sel_valid, tx_busy, scan_busy, irq_tc, irq_cf;
    logic [IDXW-1:0] sel_idx, busy_idx;
    logic [NBUF-1:0] pend, cxl_req, add_hold, tx_done, cxl_done;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    txq_tracker #(.NBUF(NBUF), .IDW(IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .add_we(add_we), .add_mask(add_mask),
        .cxl_we(cxl_we), .cxl_mask(cxl_mask), .buf_ids(buf_ids),
        .no_retry(no_retry), .tie_en(tie_en), .cfie_en(cfie_en),
        .eng_start(eng_start), .eng_ok(eng_ok), .eng_lost(eng_lost),
        .eng_err(eng_err), .sel_valid(sel_valid), .sel_idx(sel_idx),
        .tx_busy(tx_busy), .busy_idx(busy_idx), .scan_busy(scan_busy),
        .pend(pend), .cxl_req(cxl_req), .add_hold(add_hold),
        .tx_done(tx_done), .cxl_done(cxl_done), .irq_tc(irq_tc), .irq_cf(irq_cf)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_add(input logic [NBUF-1:0] m);
        add_we = 1; add_mask = m; step(); add_we = 0; add_mask = '0;
    endtask

    task automatic do_cxl(input logic [NBUF-1:0] m);
        cxl_we = 1; cxl_mask = m; step(); cxl_we = 0; cxl_mask = '0;
    endtask

    task automatic do_start();
        eng_start = 1; step(); eng_start = 0;
    endtask

    // kind: 0 ok, 1 lost, 2 error
    task automatic do_fin(input int kind);
        eng_ok = (kind == 0); eng_lost = (kind == 1); eng_err = (kind == 2);
        step(); eng_ok = 0; eng_lost = 0; eng_err = 0;
    endtask

    task automatic wait_sel(input string req);
        bit seen = 0;
        for (int k = 0; k < 40 && !seen; k++) begin
            if (sel_valid) seen = 1; else step();
        end
        chk({req, " offer appears"}, {31'd0, seen}, 32'd1);
    endtask

    task automatic settle();
        repeat (14) step();
    endtask

    function automatic logic [3:0] id_of(input int i);
        return buf_ids[i*IDW +: IDW];
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        buf_ids = {4'd9, 4'd2, 4'd5};   // buf2=9, buf1=2, buf0=5
        repeat (3) step();
        rst_n = 1;
        step();
        // reset state
        chk("R1 reset pend", pend, 0);
        chk("R5 reset cxl_req", cxl_req, 0);
        chk("R4 reset tx_done", tx_done, 0);
        chk("R6 reset cxl_done", cxl_done, 0);
        chk("R12 reset sel_valid", sel_valid, 0);
        chk("R11 reset irqs", {irq_tc, irq_cf}, 0);

        // R1: add while idle
        do_add(3'b101);
        chk("R1 pend after add", pend, 3'b101);
        chk("R1 no hold", add_hold, 0);

        // R2: add during scan is parked
        for (int k = 0; k < 10 && !scan_busy; k++) step();
        chk("R2 scan running", scan_busy, 1);
        do_add(3'b010);
        chk("R2 parked", add_hold, 3'b010);
        chk("R2 pend unchanged", pend, 3'b101);
        settle();
        chk("R2 merged", pend, 3'b111);
        chk("R2 hold drained", add_hold, 0);

        // R3 / R12: offer lowest id (buffer 1, id 2)
        wait_sel("R3");
        chk("R3 lowest id", sel_idx, 1);
        do_start();
        chk("R12 busy", tx_busy, 1);
        chk("R12 busy idx", busy_idx, 1);
        chk("R12 no offer while busy", sel_valid, 0);

        // R7: deferred cancel, then success
        do_cxl(3'b010);
        chk("R5 cxl_req set", cxl_req[1], 1);
        repeat (3) step();
        chk("R7 still pending on bus", pend[1], 1);
        tie_en = 3'b111;
        do_fin(0);
        chk("R4 pend cleared", pend[1], 0);
        chk("R7 tx_done", tx_done[1], 1);
        chk("R7 cxl_done with tx_done", cxl_done[1], 1);
        chk("R5 cxl_req cleared", cxl_req[1], 0);
        chk("R11 irq_tc", irq_tc, 1);
        chk("R11 irq_cf masked", irq_cf, 0);
        cfie_en = 3'b010;
        #1;
        chk("R11 irq_cf enabled", irq_cf, 1);

        // R10: new add clears both status bits
        do_add(3'b010);
        chk("R10 tx_done cleared", tx_done[1], 0);
        chk("R10 cxl_done cleared", cxl_done[1], 0);
        settle();
        chk("R10 pend back", pend, 3'b111);

        // R8: error without cancel retries
        wait_sel("R8");
        chk("R8 offer idx", sel_idx, 1);
        do_start();
        do_fin(2);
        chk("R8 stays pending", pend[1], 1);
        chk("R8 no cxl_done", cxl_done[1], 0);
        wait_sel("R8 retry");
        chk("R8 reoffered", sel_idx, 1);
        do_start();
        do_cxl(3'b010);
        do_fin(1);
        chk("R8 lost completes cancel pend", pend[1], 0);
        chk("R8 lost cxl_done", cxl_done[1], 1);
        chk("R8 lost no tx_done", tx_done[1], 0);

        // R9: no retry
        no_retry = 1;
        settle();
        wait_sel("R9");
        chk("R9 offer idx", sel_idx, 0);
        do_start();
        do_fin(2);
        chk("R9 pend cleared", pend[0], 0);
        chk("R9 cxl_done", cxl_done[0], 1);
        no_retry = 0;

        // R6: cancel pending buffer not on the bus
        settle();
        do_cxl(3'b100);
        chk("R6 cxl_req visible", cxl_req[2], 1);
        chk("R6 still pending", pend[2], 1);
        step();
        chk("R6 pend cleared", pend[2], 0);
        chk("R6 cxl_done", cxl_done[2], 1);
        chk("R5 cxl_req released", cxl_req[2], 0);
        settle();

        // Sweep: every mask x every id assignment from 0..3
        for (int m = 1; m < 8; m++) begin
            for (int v = 0; v < 64; v++) begin
                int best;
                buf_ids = {2'b00, 2'(v >> 4), 2'b00, 2'(v >> 2), 2'b00, 2'(v)};
                best = -1;
                for (int i = 0; i < NBUF; i++)
                    if (m[i] && (best < 0 || id_of(i) < id_of(best))) best = i;
                do_add(3'(m));
                wait_sel("R3 sweep");
                chk("R3 sweep choice", sel_idx, best);
                do_cxl(3'b111);
                repeat (4) step();
                chk("R6 sweep pend", pend, 0);
                chk("R6 sweep cxl_done", cxl_done, 3'b111);
                settle();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule